// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs register read and write transactions against an external PHY over a two-wire serial management link: a clock line that it generates and a shared data line that it drives through an output-enable. A client places a 5-bit PHY address, a 5-bit register number, a direction flag and 16 bits of write data on the request port and pulses a request strobe. The block then produces one complete frame: a synchronisation preamble, start and operation codes, both addresses, the turnaround and the data field. When the frame is over it pulses done, and for a read it presents the 16 returned bits on that same cycle.

The management clock comes from the system clock. A parameterised counter sets each half-period to the fewest whole system cycles that keep the link at or below a ceiling frequency. Read and write frames differ in length and in where the data line is released. A write releases the line for two bit times before its data and for one trailing clock after it, which gives 65 clocks. A read releases the line for one bit time, samples 16 bits and then adds one idle clock, which gives 64 clocks.

Top module: `mgmt_frame_master`

## Requirements
- R1: Every frame opens with 32 management-clock periods in which the output-enable is 1 and the data output is 1.
- R2: After the preamble the block drives the start code 0 then 1. It then drives the operation code, 1 then 0 for a read (wr_i = 0) and 0 then 1 for a write (wr_i = 1).
- R3: The next ten bits are the PHY address and then the register number, each 5 bits and sent most significant bit first, all with the output-enable at 1.
- R4: A write continues with 2 bit times with the output-enable at 0, then 16 data bits driven MSB first, then 1 bit time with the output-enable at 0, for 65 clocks in total.
- R5: A read continues with 1 bit time with the output-enable at 0, then 16 bit times in which mgmt_di_i is sampled MSB first, then 1 idle bit time with the output-enable at 0, for 64 clocks in total.
- R6: The data output and the output-enable change only while the management clock is low. They hold their values through each high phase, and read bits are captured on the rising edge.
- R7: After reset and after every frame, the management clock, the data output and the output-enable are all 0.
- R8: busy_o rises on the cycle after a request is accepted and stays high until the done pulse. A request seen while busy_o is high has no effect on the current frame and does not start a further one.
- R9: Each high and low phase of the management clock lasts HALF_CYC system cycles, where HALF_CYC = ceil(SYS_CLK_HZ / (2 * MGMT_MAX_HZ)). This is 25 at the default parameters.
- R10: rdata_o carries the sampled read value only on the done cycle of a read. It is 0 on the done cycle of a write and on every other cycle.
- R11: done_o is a single-cycle pulse, and busy_o falls on that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, accepted only when not busy |
| wr_i | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register number |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 16 | Read result, valid only with done_o |
| mgmt_clk_o | output | 1 | Management clock |
| mgmt_do_o | output | 1 | Data line output value |
| mgmt_oe_o | output | 1 | Data line output-enable |
| mgmt_di_i | input | 1 | Data line input value |

## Verification
If the bit index or the phase flag goes wrong inside the block, the effect shows on the data line at the next rising edge of the management clock. A field lands in the wrong position, the turnaround is placed wrongly, or the frame length changes from 64 or 65 clocks, and all of this is visible before done. A wrong divider count shows up within one half-period as a phase of the wrong length. A capture fault shows only on the single done cycle of a read, as a wrong value on rdata_o. The bench sweeps a spread of addresses and data patterns in both directions and compares every field against frames it builds arithmetically.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

   localparam int PRE_BITS = 32;
   localparam int ADDR_W   = 5;
   localparam int DATA_W   = 16;
   localparam int IDX_W    = 7;
   localparam int HDR_BITS = PRE_BITS + 4 + 2 * ADDR_W;   // 46
   localparam int WR_LAST  = HDR_BITS + 2 + DATA_W;       // 64
   localparam int RD_LAST  = HDR_BITS + 1 + DATA_W;       // 63
   localparam int CAP_LO   = HDR_BITS + 1;                // first sampled bit
   localparam int CAP_HI   = HDR_BITS + DATA_W;           // last sampled bit

   typedef struct packed {
      logic drive;
      logic val;
   } pin_t;

   // Pin plan for one bit time of a frame
   function automatic pin_t bit_plan(input logic [IDX_W-1:0] idx,
                                     input logic wr,
                                     input logic [ADDR_W-1:0] pa,
                                     input logic [ADDR_W-1:0] ra,
                                     input logic [DATA_W-1:0] wd);
      pin_t p;
      int   i;
      int   k;
      i = int'(idx);
      k = 0;
      p = '{1'b0, 1'b0};
      if (i < PRE_BITS) begin
         p = '{1'b1, 1'b1};
      end else if (i < PRE_BITS + 2) begin
         p = '{1'b1, (i == PRE_BITS + 1)};
      end else if (i < PRE_BITS + 4) begin
         p = '{1'b1, wr ? (i == PRE_BITS + 3) : (i == PRE_BITS + 2)};
      end else if (i < PRE_BITS + 4 + ADDR_W) begin
         k = ADDR_W - 1 - (i - PRE_BITS - 4);
         p = '{1'b1, pa[k[2:0]]};
      end else if (i < HDR_BITS) begin
         k = ADDR_W - 1 - (i - PRE_BITS - 4 - ADDR_W);
         p = '{1'b1, ra[k[2:0]]};
      end else if (wr && i >= HDR_BITS + 2 && i < HDR_BITS + 2 + DATA_W) begin
         k = DATA_W - 1 - (i - HDR_BITS - 2);
         p = '{1'b1, wd[k[3:0]]};
      end
      return p;
   endfunction

endpackage

// File: rtl/mgmt_tick_gen.sv
module mgmt_tick_gen #(
   parameter int HALF_CYC = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end

      if (HALF_CYC == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             cnt_q <= '0;
            else if (!run)                          cnt_q <= '0;
            else if (cnt_q == CNT_W'(HALF_CYC - 1)) cnt_q <= '0;
            else                                    cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == CNT_W'(HALF_CYC - 1));
      end
   endgenerate

endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
   import mgmt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] phy_addr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              mgmt_di_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              mgmt_clk_o,
   output logic              mgmt_do_o,
   output logic              mgmt_oe_o
);
   logic              busy_q, wr_q, clk_q, done_q;
   logic [ADDR_W-1:0] pa_q, ra_q;
   logic [DATA_W-1:0] wd_q, cap_q, rdata_q;
   logic [IDX_W-1:0]  idx_q;
   pin_t              pin_q;
   logic              last_bit, in_cap;

   assign last_bit = (idx_q == (wr_q ? IDX_W'(WR_LAST) : IDX_W'(RD_LAST)));
   assign in_cap   = !wr_q && (idx_q >= IDX_W'(CAP_LO)) && (idx_q <= IDX_W'(CAP_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         wr_q    <= 1'b0;
         clk_q   <= 1'b0;
         done_q  <= 1'b0;
         pa_q    <= '0;
         ra_q    <= '0;
         wd_q    <= '0;
         cap_q   <= '0;
         rdata_q <= '0;
         idx_q   <= '0;
         pin_q   <= '{1'b0, 1'b0};
      end else begin
         done_q  <= 1'b0;
         rdata_q <= '0;
         if (!busy_q) begin
            if (req_i) begin
               busy_q <= 1'b1;
               wr_q   <= wr_i;
               pa_q   <= phy_addr_i;
               ra_q   <= reg_addr_i;
               wd_q   <= wdata_i;
               cap_q  <= '0;
               idx_q  <= '0;
               pin_q  <= bit_plan('0, wr_i, phy_addr_i, reg_addr_i, wdata_i);
            end
         end else if (tick) begin
            if (!clk_q) begin
               clk_q <= 1'b1;
               if (in_cap) cap_q <= {cap_q[DATA_W-2:0], mgmt_di_i};
            end else begin
               clk_q <= 1'b0;
               if (last_bit) begin
                  busy_q  <= 1'b0;
                  done_q  <= 1'b1;
                  rdata_q <= wr_q ? '0 : cap_q;
                  pin_q   <= '{1'b0, 1'b0};
               end else begin
                  idx_q <= idx_q + 1'b1;
                  pin_q <= bit_plan(idx_q + 1'b1, wr_q, pa_q, ra_q, wd_q);
               end
            end
         end
      end
   end

   assign busy_o     = busy_q;
   assign done_o     = done_q;
   assign rdata_o    = rdata_q;
   assign mgmt_clk_o = clk_q;
   assign mgmt_do_o  = pin_q.val;
   assign mgmt_oe_o  = pin_q.drive;

   // R6: pin values hold through each high phase
   a_r6_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_clk_o |-> $stable({mgmt_do_o, mgmt_oe_o}));
   // R7: quiet link whenever no frame is running
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mgmt_clk_o && !mgmt_do_o && !mgmt_oe_o));
   // R11: done lasts one cycle
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R11: busy only drops together with done
   a_r11_busy_falls_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
   // R10: no read data outside the done cycle
   a_r10_rdata_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (rdata_o == '0));
   // R5: line released for the whole read tail
   a_r5_read_tail_released: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !wr_q && idx_q >= IDX_W'(HDR_BITS)) |-> !mgmt_oe_o);
   // R4: line released at write turnaround and trailing clock
   a_r4_write_release: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && wr_q && (idx_q == IDX_W'(HDR_BITS) || idx_q == IDX_W'(HDR_BITS + 1)
                          || idx_q == IDX_W'(WR_LAST))) |-> !mgmt_oe_o);
   // R1: preamble is driven high
   a_r1_preamble_high: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && idx_q < IDX_W'(PRE_BITS)) |-> (mgmt_oe_o && mgmt_do_o));

endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master #(
   parameter int unsigned SYS_CLK_HZ  = 125_000_000,
   parameter int unsigned MGMT_MAX_HZ = 2_500_000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_i,
   input  logic        wr_i,
   input  logic [4:0]  phy_addr_i,
   input  logic [4:0]  reg_addr_i,
   input  logic [15:0] wdata_i,
   output logic        busy_o,
   output logic        done_o,
   output logic [15:0] rdata_o,
   output logic        mgmt_clk_o,
   output logic        mgmt_do_o,
   output logic        mgmt_oe_o,
   input  logic        mgmt_di_i
);
   localparam int HALF_CYC = int'((SYS_CLK_HZ + 2 * MGMT_MAX_HZ - 1) / (2 * MGMT_MAX_HZ));
   localparam int CHK_W    = $clog2(HALF_CYC + 2) + 1;

   generate
      if (MGMT_MAX_HZ == 0) begin : g_bad_max
         $error("MGMT_MAX_HZ must be nonzero");
      end
      if (HALF_CYC < 1) begin : g_bad_div
         $error("derived half period must be at least one cycle");
      end
   endgenerate

   logic tick;

   mgmt_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_o),
      .tick  (tick)
   );

   mgmt_frame_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .req_i      (req_i),
      .wr_i       (wr_i),
      .phy_addr_i (phy_addr_i),
      .reg_addr_i (reg_addr_i),
      .wdata_i    (wdata_i),
      .mgmt_di_i  (mgmt_di_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .rdata_o    (rdata_o),
      .mgmt_clk_o (mgmt_clk_o),
      .mgmt_do_o  (mgmt_do_o),
      .mgmt_oe_o  (mgmt_oe_o)
   );

   // Phase-length watch: cycles since the last clock-line change
   logic [CHK_W-1:0] ph_cnt_q;
   logic             clk_prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_cnt_q   <= '0;
         clk_prev_q <= 1'b0;
      end else begin
         clk_prev_q <= mgmt_clk_o;
         if (!busy_o)                      ph_cnt_q <= '0;
         else if (mgmt_clk_o != clk_prev_q) ph_cnt_q <= CHK_W'(1);
         else                              ph_cnt_q <= ph_cnt_q + 1'b1;
      end
   end

   // R9: every phase within a frame spans HALF_CYC cycles
   a_r9_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && mgmt_clk_o != clk_prev_q) |-> (ph_cnt_q == CHK_W'(HALF_CYC)));
   // R8: a request while busy does not disturb busy
   a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && req_i) |=> (busy_o || done_o));

endmodule

// File: tb/mgmt_frame_master_bench.sv
module mgmt_frame_master_bench;
   localparam int PERIOD = 8;
   localparam int HALF   = (125_000_000 + 5_000_000 - 1) / 5_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0, wr_i = 1'b0;
   logic [4:0]  phy_addr_i = '0, reg_addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic        busy_o, done_o, mgmt_clk_o, mgmt_do_o, mgmt_oe_o;
   logic [15:0] rdata_o;
   logic        mgmt_di_i = 1'b1;

   int checks = 0, failures = 0, cyc = 0;
   int bit_cnt = 0, half_bad = 0, run_len = 0, r6_bad = 0, ndone = 0;
   logic last_lvl = 1'b0;
   logic prev_hi = 1'b0;
   logic [1:0] prev_pins = '0;
   logic [15:0] resp_q = '0;
   logic obs_d [0:69];
   logic obs_oe [0:69];

   always #(PERIOD/2) clk = ~clk;

   mgmt_frame_master u_mgmt_frame_master (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i),
      .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
      .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
      .mgmt_clk_o(mgmt_clk_o), .mgmt_do_o(mgmt_do_o), .mgmt_oe_o(mgmt_oe_o),
      .mgmt_di_i(mgmt_di_i));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // PHY model: record pins at rising edges, answer on falling edges
   always @(posedge mgmt_clk_o) begin
      if (bit_cnt < 70) begin
         obs_d[bit_cnt]  = mgmt_do_o;
         obs_oe[bit_cnt] = mgmt_oe_o;
      end
      bit_cnt++;
   end
   always @(negedge mgmt_clk_o) begin
      if (bit_cnt >= 47 && bit_cnt <= 62) mgmt_di_i <= resp_q[62 - bit_cnt];
      else                                mgmt_di_i <= 1'b1;
   end

   // Phase lengths, pin stability in high phase, done count
   always @(negedge clk) begin
      if (busy_o) begin
         if (mgmt_clk_o != last_lvl) begin
            if (run_len != HALF) half_bad++;
            run_len = 1;
         end else run_len++;
         if (mgmt_clk_o && prev_hi && {mgmt_do_o, mgmt_oe_o} != prev_pins) r6_bad++;
      end else run_len = 0;
      last_lvl  = mgmt_clk_o;
      prev_hi   = mgmt_clk_o;
      prev_pins = {mgmt_do_o, mgmt_oe_o};
      if (done_o) ndone++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run_frame(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] wd, input logic [15:0] resp, input bit inject);
      logic [64:0] exp_d, exp_oe, got_d, got_oe;
      int wait_n;
      int leak;
      int flen;
      leak = 0;
      resp_q = resp;
      bit_cnt = 0; half_bad = 0; r6_bad = 0; ndone = 0;
      @(negedge clk);
      req_i = 1'b1; wr_i = wr; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
      @(negedge clk);
      req_i = 1'b0;
      chk(busy_o === 1'b1, "R8 busy after accept", busy_o, 1);
      if (inject) begin
         repeat (100) @(negedge clk);
         req_i = 1'b1; wr_i = ~wr; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;
         @(negedge clk);
         req_i = 1'b0;
      end
      wait_n = 0;
      while (done_o !== 1'b1 && wait_n < 5000) begin
         if (rdata_o !== 16'h0) leak++;
         @(negedge clk);
         wait_n++;
      end
      chk(done_o === 1'b1, "R11 done seen", done_o, 1);
      chk(busy_o === 1'b0, "R11 busy low with done", busy_o, 0);
      chk(rdata_o === (wr ? 16'h0 : resp), "R10 rdata on done", rdata_o, wr ? 16'h0 : resp);
      chk({mgmt_clk_o, mgmt_do_o, mgmt_oe_o} === 3'b000, "R7 idle after frame",
          {mgmt_clk_o, mgmt_do_o, mgmt_oe_o}, 0);
      @(negedge clk);
      chk(done_o === 1'b0 && rdata_o === 16'h0, "R11 R10 pulse ends", {done_o, rdata_o}, 0);
      repeat (60) @(negedge clk);
      chk(busy_o === 1'b0 && ndone == 1, "R8 no extra frame", {busy_o, 8'(ndone)}, 1);
      chk(leak == 0, "R10 rdata zero before done", leak, 0);
      flen = wr ? 65 : 64;
      chk(bit_cnt == flen, wr ? "R4 write length" : "R5 read length", bit_cnt, flen);
      chk(half_bad == 0, "R9 half period", half_bad, 0);
      chk(r6_bad == 0, "R6 stable high phase", r6_bad, 0);
      got_d = '0; got_oe = '0;
      for (int k = 0; k < flen && k < 65; k++) begin
         got_d[64 - k]  = obs_d[k];
         got_oe[64 - k] = obs_oe[k];
      end
      if (wr) begin
         exp_d  = {{32{1'b1}}, 2'b01, 2'b01, pa, ra, 2'b00, wd, 1'b0};
         exp_oe = {{46{1'b1}}, 2'b00, {16{1'b1}}, 1'b0};
      end else begin
         exp_d  = {{32{1'b1}}, 2'b01, 2'b10, pa, ra, 19'h0};
         exp_oe = {{46{1'b1}}, 19'h0};
      end
      chk(got_d[64:33] == exp_d[64:33] && got_oe[64:33] == exp_oe[64:33], "R1 preamble",
          {got_d[64:33], got_oe[64:33]}, {exp_d[64:33], exp_oe[64:33]});
      chk(got_d[32:29] == exp_d[32:29] && got_oe[32:29] == 4'hF, "R2 start/op",
          got_d[32:29], exp_d[32:29]);
      chk(got_d[28:19] == exp_d[28:19] && got_oe[28:19] == 10'h3FF, "R3 addresses",
          got_d[28:19], exp_d[28:19]);
      chk(got_d[18:0] == exp_d[18:0] && got_oe[18:0] == exp_oe[18:0],
          wr ? "R4 write tail" : "R5 read tail",
          {got_oe[18:0], got_d[18:0]}, {exp_oe[18:0], exp_d[18:0]});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({busy_o, done_o, mgmt_clk_o, mgmt_do_o, mgmt_oe_o} === 5'b0 && rdata_o === 16'h0,
          "R7 reset state", {busy_o, done_o, mgmt_clk_o, mgmt_do_o, mgmt_oe_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({busy_o, mgmt_clk_o, mgmt_oe_o} === 3'b0, "R7 idle after reset",
          {busy_o, mgmt_clk_o, mgmt_oe_o}, 0);
      run_frame(1'b1, 5'h00, 5'h00, 16'h0000, 16'h0000, 1'b0);
      run_frame(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'hFFFF, 1'b0);
      run_frame(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 1'b1);
      run_frame(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0001, 1'b1);
      for (int i = 0; i < 5; i++) begin
         run_frame(1'b0, 5'(i * 7 + 3), 5'(29 - i * 6), 16'(16'h1357 * (i + 1)),
                   16'(16'hA5C3 ^ (16'h0F1E << i)), 1'b0);
         run_frame(1'b1, 5'(i * 11 + 1), 5'(i * 3 + 16), 16'(16'h8001 + 16'h2468 * i),
                   16'h0, 1'b0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule